// File: doc/BRIEF.md
# Reloading Interval Timer Bank

This block holds three down-counting interval timers and one up-counting timebase behind a small word-addressed register interface. Two of the timers are 16 bits wide and the third is 32 bits wide. Each one decrements on a tick strobe picked by its control word. When it underflows it raises its own interrupt and restarts. The restart value is either the programmed load value or all-ones. A pending interrupt stays asserted until software writes to that timer's clear register.

The timebase is 40 bits wide and counts up on its own tick strobe. It never interrupts. Software starts or stops it through a bit in its upper register, and measures elapsed ticks by taking the difference of two reads of the lower register. The clock dividers that make the tick strobes are outside this block. Every tick input is a single-cycle enable in the block's clock domain.

Register writes take effect at the next clock edge. Reads are combinational from the address.

Top module: `reload_timer_bank`

## Requirements
- R1: After reset, every readable register reads zero and all three interrupt outputs are low.
- R2: With control 0xC8 and load value N-1, a timer raises its interrupt N ticks after it is enabled. It reloads itself and fires again every N ticks.
- R3: The value register of timer t (word address 4t+1) returns the live count. It falls by one per selected tick.
- R4: Any write to the clear register of timer t (word address 4t+3) drops that timer's interrupt on the next edge. An underflow in the same cycle as the clear keeps the interrupt set.
- R5: Control bit 7 enables a timer. While it is 0, ticks change neither the count nor the interrupt.
- R6: Control bit 3 selects the tick: 1 counts on tick_fast and 0 counts on tick_slow. The other strobe has no effect.
- R7: Control bit 6 selects periodic mode. When it is 0, an underflow reloads the count with all-ones for the timer's width and still raises the interrupt.
- R8: A load write (word address 4t) to a disabled timer sets the count at once. On a running timer the count is left unchanged until the next selected tick, which loads the new value.
- R9: Timers 0 and 1 keep only the low 16 bits of a load write. Timer 2 keeps all 32 bits.
- R10: Writing the timebase upper register (word 13) sets the run bit from bit 8 and zeroes the count. While running, the count rises by one per tick_tb. Word 12 reads count bits 31:0. Word 13 reads the run bit at bit 8 and count bits 39:32 at bits 7:0. The timebase never drives an interrupt.
- R11: Control registers (word 4t+2) keep only bits 7, 6 and 3 on readback. Clear registers and unmapped words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_fast | input | 1 | Fast tick strobe for the interval timers |
| tick_slow | input | 1 | Slow tick strobe for the interval timers |
| tick_tb | input | 1 | Tick strobe for the timebase |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed word |
| irq | output | 3 | Per-timer pending interrupt |

## Verification
The assertions assume that each tick strobe is a single-cycle, synchronous pulse that the block may see on any cycle. They also assume that a write lands in exactly one cycle, so a clear or load write can coincide with a tick only when the stimulus arranges it. The bench drives ticks and writes at the falling clock edge and holds each for one cycle. It drives a tick together with a clear write only in the single test of the set-wins rule. Elsewhere it keeps clears and loads apart from ticks, so the no-tick preconditions of the clear and hold properties are actually reached.

// File: rtl/reload_timer_bank.sv
`timescale 1ns/1ps
module reload_timer_bank #(
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 32,
  parameter int TB_W    = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_fast,
  input  logic        tick_slow,
  input  logic        tick_tb,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [2:0]  irq
);
  localparam logic [31:0] MASK_S = 32'((64'd1 << SHORT_W) - 64'd1);
  localparam logic [31:0] MASK_L = 32'((64'd1 << LONG_W) - 64'd1);
  localparam int HI_W = TB_W - 32;
  localparam logic [3:0] A_TB_LO = 4'd12;
  localparam logic [3:0] A_TB_HI = 4'd13;

  logic [2:0][31:0] cnt, ld;
  logic [2:0][7:0]  ctl;
  logic [2:0]       run;
  logic [TB_W-1:0]  tb_cnt;
  logic             tb_en;

  for (genvar i = 0; i < 3; i++) begin : g_tmr
    localparam logic [31:0] MSK = (i == 2) ? MASK_L : MASK_S;
    logic [31:0] c, l;
    logic [7:0]  k;
    logic        p, q;
    wire base_hit = wr_en && (addr[3:2] == 2'(i));
    wire wr_ld  = base_hit && (addr[1:0] == 2'd0);
    wire wr_ctl = base_hit && (addr[1:0] == 2'd2);
    wire wr_clr = base_hit && (addr[1:0] == 2'd3);
    wire tk = k[7] && (k[3] ? tick_fast : tick_slow);
    wire uf = tk && !p && (c == 32'd0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c <= '0; l <= '0; k <= '0; p <= 1'b0; q <= 1'b0;
      end else begin
        if (tk) begin
          if (p) begin
            c <= l;
            p <= 1'b0;
          end else if (c == 32'd0) c <= k[6] ? l : MSK;
          else c <= c - 32'd1;
        end
        if (wr_ld) begin
          l <= wdata & MSK;
          if (k[7]) p <= 1'b1;
          else begin
            c <= wdata & MSK;
            p <= 1'b0;
          end
        end
        if (wr_ctl) k <= wdata[7:0] & 8'hC8;
        if (wr_clr) q <= 1'b0;
        if (uf) q <= 1'b1;
      end
    end

    assign cnt[i] = c;
    assign ld[i]  = l;
    assign ctl[i] = k;
    assign run[i] = k[7];
    assign irq[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_cnt <= '0;
      tb_en  <= 1'b0;
    end else if (wr_en && addr == A_TB_HI) begin
      tb_en  <= wdata[8];
      tb_cnt <= '0;
    end else if (tb_en && tick_tb) begin
      tb_cnt <= tb_cnt + 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_TB_LO) rdata = tb_cnt[31:0];
    else if (addr == A_TB_HI) begin
      rdata[HI_W-1:0] = tb_cnt[TB_W-1:32];
      rdata[8] = tb_en;
    end else if (addr[3:2] != 2'd3) begin
      case (addr[1:0])
        2'd0:    rdata = ld[addr[3:2]];
        2'd1:    rdata = cnt[addr[3:2]];
        2'd2:    rdata = {24'd0, ctl[addr[3:2]]};
        default: rdata = '0;
      endcase
    end
  end
endmodule

module reload_timer_bank_chk #(parameter int TB_W = 40) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_fast,
  input logic            tick_slow,
  input logic            tick_tb,
  input logic            wr_en,
  input logic [3:0]      addr,
  input logic [2:0]      irq,
  input logic [2:0]      run,
  input logic [31:0]     c0,
  input logic [TB_W-1:0] tb_cnt,
  input logic            tb_en
);
  a_r2_irq0_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[0]) |-> $past(tick_fast || tick_slow));
  a_r2_irq2_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[2]) |-> $past(tick_fast || tick_slow));
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd3 && !tick_fast && !tick_slow) |=> !irq[0]);
  a_r4_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq[1]) |-> $past(wr_en && addr == 4'd7));
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] && !(wr_en && addr == 4'd0)) |=> $stable(c0));
  a_r10_tb_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_tb && !(wr_en && addr == 4'd13)) |=> $stable(tb_cnt));
  a_r10_tb_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_tb && tb_en && !(wr_en && addr == 4'd13)) |=> tb_cnt == $past(tb_cnt) + 1'b1);
endmodule

bind reload_timer_bank reload_timer_bank_chk #(.TB_W(TB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
  .tick_tb(tick_tb), .wr_en(wr_en), .addr(addr), .irq(irq), .run(run),
  .c0(cnt[0]), .tb_cnt(tb_cnt), .tb_en(tb_en)
);

// File: tb/reload_timer_bank_tb.sv
`timescale 1ns/1ps
module reload_timer_bank_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_fast = 0, tick_slow = 0, tick_tb = 0, wr_en = 0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [2:0] irq;
  int nchk = 0, nfail = 0;

  reload_timer_bank u_dut (.clk(clk), .rst_n(rst_n), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .tick_tb(tick_tb), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic tk(int which, int n);
    for (int j = 0; j < n; j++) begin
      if (which == 0) tick_fast = 1; else if (which == 1) tick_slow = 1; else tick_tb = 1;
      @(negedge clk);
      tick_fast = 0; tick_slow = 0; tick_tb = 0;
    end
  endtask

  task automatic setup(int t, logic [31:0] ldv, logic [7:0] mode);
    wr(4'(4*t+2), 32'h48);
    wr(4'(4*t), ldv);
    wr(4'(4*t+2), {24'd0, mode});
    wr(4'(4*t+3), 32'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n;
    int lens[8] = '{1, 2, 3, 5, 8, 13, 20, 300};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v); chk("R1 reset read", v, 0);
    end
    chk("R1 reset irq", {29'd0, irq}, 0);

    for (int t = 0; t < 3; t++)
      foreach (lens[i]) begin
        setup(t, lens[i] - 1, 8'hC8);
        rd(4'(4*t+1), v); chk("R8 idle load sets count", v, lens[i] - 1);
        for (int rep = 0; rep < 2; rep++) begin
          n = 0;
          while (!irq[t] && n < lens[i] + 5) begin tk(0, 1); n++; end
          chk("R2 period", n, lens[i]);
          rd(4'(4*t+1), v); chk("R2 reload", v, lens[i] - 1);
          wr(4'(4*t+3), 32'hDEAD);
          chk("R4 clear", {31'd0, irq[t]}, 0);
        end
      end

    setup(2, 32'd69999, 8'hC8);
    n = 0;
    while (!irq[2] && n < 70010) begin tk(0, 1); n++; end
    chk("R2 R9 long period", n, 70000);

    setup(0, 32'd9, 8'hC8);
    tk(0, 3);
    rd(4'd1, v); chk("R3 live count", v, 6);

    setup(0, 32'd9, 8'hC0);
    tk(0, 4);
    rd(4'd1, v); chk("R6 fast ignored", v, 9);
    tk(1, 2);
    rd(4'd1, v); chk("R6 slow counts", v, 7);

    setup(0, 32'd9, 8'hC8);
    wr(4'd2, 32'h48);
    tk(0, 5); tk(1, 5);
    rd(4'd1, v); chk("R5 disabled count", v, 9);
    chk("R5 disabled irq", {31'd0, irq[0]}, 0);

    setup(1, 32'd2, 8'h88);
    tk(0, 3);
    rd(4'd5, v); chk("R7 wrap value", v, 32'hFFFF);
    chk("R7 wrap irq", {31'd0, irq[1]}, 1);
    setup(2, 32'd0, 8'h88);
    tk(0, 1);
    rd(4'd9, v); chk("R7 wrap long", v, 32'hFFFFFFFF);

    setup(0, 32'd9, 8'hC8);
    tk(0, 2);
    wr(4'd0, 32'd4);
    rd(4'd1, v); chk("R8 run load deferred", v, 7);
    tk(0, 1);
    rd(4'd1, v); chk("R8 run load applied", v, 4);
    tk(0, 1);
    rd(4'd1, v); chk("R8 then decrements", v, 3);

    setup(1, 32'd0, 8'hC8);
    tk(0, 1);
    chk("R4 irq before race", {31'd0, irq[1]}, 1);
    wr_en = 1; addr = 4'd7; wdata = 0; tick_fast = 1;
    @(negedge clk);
    wr_en = 0; tick_fast = 0;
    chk("R4 underflow beats clear", {31'd0, irq[1]}, 1);
    wr(4'd7, 0);
    chk("R4 plain clear", {31'd0, irq[1]}, 0);

    wr(4'd2, 32'h48); wr(4'd0, 32'h12345);
    rd(4'd0, v); chk("R9 short load", v, 32'h2345);
    rd(4'd1, v); chk("R9 short count", v, 32'h2345);
    wr(4'd10, 32'h48); wr(4'd8, 32'h12345);
    rd(4'd8, v); chk("R9 long load", v, 32'h12345);

    wr(4'd6, 32'hFF);
    rd(4'd6, v); chk("R11 ctl mask", v, 32'hC8);
    rd(4'd7, v); chk("R11 clear reads zero", v, 0);
    rd(4'd14, v); chk("R11 unmapped", v, 0);

    wr(4'd2, 32'h48); wr(4'd6, 32'h48); wr(4'd10, 32'h48);
    wr(4'd3, 0); wr(4'd7, 0); wr(4'd11, 0);
    tk(2, 5);
    rd(4'd12, v); chk("R10 stopped", v, 0);
    wr(4'd13, 32'h100);
    rd(4'd13, v); chk("R10 high run bit", v, 32'h100);
    tk(2, 37);
    rd(4'd12, v); chk("R10 count", v, 37);
    chk("R10 no irq", {29'd0, irq}, 0);
    tk(2, 3);
    rd(4'd12, v); chk("R10 diff", v - 32'd37, 3);
    wr(4'd13, 32'h0);
    rd(4'd12, v); chk("R10 cleared", v, 0);
    rd(4'd13, v); chk("R10 stopped high", v, 0);
    tk(2, 4);
    rd(4'd12, v); chk("R10 stays", v, 0);

    finish_run();
  end
endmodule